// File: doc/BRIEF.md
# Down-Counting Period Timer with Update Control

This block is a down-counter with a programmable clock divider. It produces a periodic event stream. The counter starts at a reload value, steps down once per divider terminal count, and on the step after zero it wraps back to the reload value and emits an underflow pulse. The reload value and the divide ratio are each held twice. Software writes a preload copy. The counter and divider run from an active copy. The active copy only changes on an update event, so a new period length never cuts into the period already running.

Software reaches the block through a synchronous write port with four word addresses:

| Address | Contents |
|---|---|
| 0 | Control word: bit 0 enables counting, bit 1 inhibits updates, bit 2 selects quiet forced updates |
| 1 | Reload preload |
| 2 | Divider preload |
| 3 | Command word: bit 0 written as 1 forces an update; bit 1 written as 0 clears the update flag |

An update event copies both preloads into the active copies and pulses `update_o`. The update flag is sticky and drives `irq_o`. The inhibit bit blocks update events; while it is set, wraps and forced restarts reuse the active reload value. The quiet-select bit keeps a forced update from setting the flag, but a natural wrap still sets it. Counter, pulses and flag are all registered, so every effect appears in the cycle after the causing clock edge. The port carries no stream data, so there is no valid/ready handshake: every pin is plain control or status.

Top module: `dntmr_core`

## Requirements
- R1: With counting enabled, divider active value P and reload active value A, one wrap occurs every (A+1)*(P+1) clock cycles.
- R2: The cycle after a reload, `cnt_o` equals the reload value. It then drops by one at each divider terminal count.
- R3: A reload preload written in the middle of a period does not change that period's length. The next period uses the new value.
- R4: While control bit 1 (inhibit) is 1, a wrap pulses `underflow_o` but not `update_o`. The flag does not set, and the active reload and divide values are not changed by preload writes.
- R5: A forced update (command bit 0 = 1) while inhibit is 1 restarts the counter from the active reload value and restarts the divider from 0. It emits no update pulse.
- R6: A forced update while control bit 2 (quiet) is 1 pulses `update_o` but leaves the flag clear. A wrap with quiet = 1 still sets the flag.
- R7: The update flag, seen on `irq_o`, stays set until a command write with bit 1 = 0. A command write with bit 1 = 1 leaves it set.
- R8: With control bit 0 (enable) at 0, `cnt_o` holds its value. A forced update still reloads it.
- R9: After reset, `cnt_o` = 0, `irq_o` = 0, and neither pulse output is high.
- R10: A forced update with inhibit = 0 loads both preloads at once. The next cycle shows `update_o` = 1 and `cnt_o` = the new reload value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe for one cycle |
| wr_addr | input | 2 | Word address (0 control, 1 reload, 2 divider, 3 command) |
| wr_data | input | CNT_W (16) | Write data |
| cnt_o | output | CNT_W (16) | Present counter value |
| underflow_o | output | 1 | One-cycle pulse on each wrap |
| update_o | output | 1 | One-cycle pulse on each update event |
| irq_o | output | 1 | Sticky update flag |

## Verification
The checker assumes that every change of control state arrives through the write port. It also assumes that a wrap and a forced update landing on the same edge count as a single forced update, with no underflow pulse. The bench drives one write at a time, away from the clock edge. It never writes a preload in the same cycle as a forced update, so the expected values follow from arithmetic on the reload and divide values alone. It freezes counting before any step whose outcome would otherwise depend on where the counter happens to be in its period.

// File: rtl/dntmr_pkg.sv
`timescale 1ns/1ps
package dntmr_pkg;
  localparam int ADDR_W = 2;
  typedef logic [ADDR_W-1:0] addr_t;

  localparam addr_t ADR_CTRL = 2'd0;
  localparam addr_t ADR_RLD  = 2'd1;
  localparam addr_t ADR_DIV  = 2'd2;
  localparam addr_t ADR_CMD  = 2'd3;

  localparam int CMD_FORCE_BIT = 0;
  localparam int CMD_KEEP_BIT  = 1;
  localparam int CTRL_BITS     = 3;

  // bit 0 enable, bit 1 inhibit, bit 2 quiet-forced
  typedef struct packed {
    logic quiet;
    logic inhibit;
    logic enable;
  } ctrl_t;
endpackage

// File: rtl/dntmr_regs.sv
`timescale 1ns/1ps
module dntmr_regs
  import dntmr_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  addr_t            wr_addr,
  input  logic [CNT_W-1:0] wr_data,
  output ctrl_t            ctrl,
  output logic [CNT_W-1:0] rld_pre,
  output logic [DIV_W-1:0] div_pre,
  output logic             force_upd,
  output logic             flag_clr
);
  logic cmd_hit;
  logic unused_hi;

  assign cmd_hit   = wr_en && (wr_addr == ADR_CMD);
  assign force_upd = cmd_hit && wr_data[CMD_FORCE_BIT];
  assign flag_clr  = cmd_hit && !wr_data[CMD_KEEP_BIT];
  assign unused_hi = ^wr_data[CNT_W-1:CTRL_BITS];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl    <= '0;
      rld_pre <= '1;
      div_pre <= '0;
    end else if (wr_en) begin
      case (wr_addr)
        ADR_CTRL: ctrl    <= ctrl_t'(wr_data[CTRL_BITS-1:0]);
        ADR_RLD:  rld_pre <= wr_data;
        ADR_DIV:  div_pre <= wr_data[DIV_W-1:0];
        default:  ;
      endcase
    end
  end
endmodule

// File: rtl/dntmr_div.sv
`timescale 1ns/1ps
module dntmr_div #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             restart,
  input  logic             load,
  input  logic [DIV_W-1:0] div_pre,
  output logic             tick
);
  logic [DIV_W-1:0] div_cnt;
  logic [DIV_W-1:0] div_act;

  assign tick = enable && (div_cnt == div_act);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      div_cnt <= '0;
    end else if (restart || tick) begin
      div_cnt <= '0;
    end else if (enable) begin
      div_cnt <= div_cnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      div_act <= '0;
    end else if (load) begin
      div_act <= div_pre;
    end
  end
endmodule

// File: rtl/dntmr_cnt.sv
`timescale 1ns/1ps
module dntmr_cnt #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             force_upd,
  input  logic             flag_clr,
  input  logic             inhibit,
  input  logic             quiet,
  input  logic [CNT_W-1:0] rld_pre,
  output logic             upd_evt,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CNT_W-1:0] rld_act,
  output logic             underflow_o,
  output logic             update_o,
  output logic             flag_o
);
  logic wrap;
  logic reload;
  logic flag_set;
  logic [CNT_W-1:0] cnt_next;

  // a forced update on the same edge as a wrap takes precedence
  assign wrap     = tick && (cnt_o == '0) && !force_upd;
  assign reload   = wrap || force_upd;
  assign upd_evt  = reload && !inhibit;
  assign flag_set = (wrap && !inhibit) || (force_upd && !inhibit && !quiet);

  always_comb begin
    cnt_next = cnt_o;
    if (reload)    cnt_next = upd_evt ? rld_pre : rld_act;
    else if (tick) cnt_next = cnt_o - 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_o       <= '0;
      rld_act     <= '1;
      underflow_o <= 1'b0;
      update_o    <= 1'b0;
    end else begin
      cnt_o       <= cnt_next;
      underflow_o <= wrap;
      update_o    <= upd_evt;
      if (upd_evt) rld_act <= rld_pre;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)        flag_o <= 1'b0;
    else if (flag_set) flag_o <= 1'b1;
    else if (flag_clr) flag_o <= 1'b0;
  end
endmodule

// File: rtl/dntmr_core.sv
`timescale 1ns/1ps
module dntmr_core
  import dntmr_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int DIV_W = CNT_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [1:0]       wr_addr,
  input  logic [CNT_W-1:0] wr_data,
  output logic [CNT_W-1:0] cnt_o,
  output logic             underflow_o,
  output logic             update_o,
  output logic             irq_o
);
  ctrl_t            ctrl;
  logic [CNT_W-1:0] rld_pre;
  logic [CNT_W-1:0] rld_act;
  logic [DIV_W-1:0] div_pre;
  logic             force_upd;
  logic             flag_clr;
  logic             tick;
  logic             upd_evt;
  logic             ctl_en;
  logic             ctl_inh;
  logic             ctl_quiet;

  assign ctl_en    = ctrl.enable;
  assign ctl_inh   = ctrl.inhibit;
  assign ctl_quiet = ctrl.quiet;

  dntmr_regs #(.CNT_W(CNT_W), .DIV_W(DIV_W)) regs_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .ctrl      (ctrl),
    .rld_pre   (rld_pre),
    .div_pre   (div_pre),
    .force_upd (force_upd),
    .flag_clr  (flag_clr)
  );

  dntmr_div #(.DIV_W(DIV_W)) div_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .enable  (ctl_en),
    .restart (force_upd),
    .load    (upd_evt),
    .div_pre (div_pre),
    .tick    (tick)
  );

  dntmr_cnt #(.CNT_W(CNT_W)) cnt_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .tick        (tick),
    .force_upd   (force_upd),
    .flag_clr    (flag_clr),
    .inhibit     (ctl_inh),
    .quiet       (ctl_quiet),
    .rld_pre     (rld_pre),
    .upd_evt     (upd_evt),
    .cnt_o       (cnt_o),
    .rld_act     (rld_act),
    .underflow_o (underflow_o),
    .update_o    (update_o),
    .flag_o      (irq_o)
  );
endmodule

// File: rtl/dntmr_chk.sv
`timescale 1ns/1ps
module dntmr_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ctl_en,
  input logic             ctl_inh,
  input logic             force_upd,
  input logic [CNT_W-1:0] rld_act,
  input logic [CNT_W-1:0] cnt_o,
  input logic             underflow_o,
  input logic             update_o,
  input logic             irq_o
);
  AST_UPD_BLOCKED_BY_INH: assert property (@(posedge clk) disable iff (!rst_n)
    update_o |-> !$past(ctl_inh)); // R4

  AST_WRAP_LOADS_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
    underflow_o |-> (cnt_o == rld_act)); // R2

  AST_FLAG_RISE_ON_UPD: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_o) |-> update_o); // R6

  AST_HOLD_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(ctl_en) && !$past(force_upd)) |-> $stable(cnt_o)); // R8

  AST_FORCE_UPDATES: assert property (@(posedge clk) disable iff (!rst_n)
    (force_upd && !ctl_inh) |=> update_o); // R10

  AST_FORCE_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    force_upd |=> !underflow_o); // R5
endmodule

bind dntmr_core dntmr_chk #(.CNT_W(CNT_W)) chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .ctl_en      (ctl_en),
  .ctl_inh     (ctl_inh),
  .force_upd   (force_upd),
  .rld_act     (rld_act),
  .cnt_o       (cnt_o),
  .underflow_o (underflow_o),
  .update_o    (update_o),
  .irq_o       (irq_o)
);

// File: tb/dntmr_core_tb.sv
`timescale 1ns/1ps
module dntmr_core_tb_top;
  localparam int W = 16;
  localparam logic [1:0] A_CTRL = 2'd0, A_RLD = 2'd1, A_DIV = 2'd2, A_CMD = 2'd3;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         wr_en = 1'b0;
  logic [1:0]   wr_addr = '0;
  logic [W-1:0] wr_data = '0;
  logic [W-1:0] cnt_o;
  logic         underflow_o, update_o, irq_o;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  dntmr_core #(.CNT_W(W)) dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .cnt_o(cnt_o), .underflow_o(underflow_o),
    .update_o(update_o), .irq_o(irq_o)
  );

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input int d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = W'(d);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic count_to(input bit sel_udf, output int n);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!(sel_udf ? underflow_o : update_o) && n < 5000);
  endtask

  task automatic idle(input int k);
    for (int i = 0; i < k; i++) @(negedge clk);
  endtask

  initial begin
    int n, per, ucnt, held;
    idle(3);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R9 cnt", cnt_o, 0);
    chk("R9 irq", irq_o, 0);
    chk("R9 pulses", {underflow_o, update_o}, 0);

    // sweep of reload and divide values
    for (int a = 0; a < 6; a++) begin
      for (int p = 0; p < 4; p++) begin
        per = (a + 1) * (p + 1);
        wr(A_CTRL, 1);
        wr(A_RLD, a);
        wr(A_DIV, p);
        wr(A_CMD, 3);
        chk("R10 update", update_o, 1);
        chk("R10 cnt", cnt_o, a);
        idle(p + 1);
        chk("R2 step", cnt_o, (a == 0) ? 0 : a - 1);
        if (a > 0) begin
          count_to(1'b0, n);
          chk("R1 first", n, per - (p + 1));
        end
        count_to(1'b0, n);
        chk("R1 period", n, per);
        count_to(1'b0, n);
        chk("R1 period2", n, per);
      end
    end

    // R3: preload change mid-period
    wr(A_RLD, 3); wr(A_DIV, 0); wr(A_CMD, 3);
    count_to(1'b0, n);
    wr(A_RLD, 6);
    count_to(1'b0, n);
    chk("R3 old period", n, 2);
    count_to(1'b0, n);
    chk("R3 new period", n, 7);

    // R4: inhibit blocks updates
    wr(A_RLD, 4); wr(A_DIV, 1); wr(A_CMD, 3);
    wr(A_CTRL, 3);
    wr(A_CMD, 0);
    wr(A_RLD, 1);
    wr(A_DIV, 0);
    ucnt = 0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (update_o) ucnt++;
    end
    chk("R4 no update", ucnt, 0);
    chk("R4 flag", irq_o, 0);
    count_to(1'b1, n);
    count_to(1'b1, n);
    chk("R4 shadow kept", n, 10);

    // R5: forced restart while inhibited
    wr(A_CMD, 3);
    chk("R5 cnt", cnt_o, 4);
    chk("R5 no update", update_o, 0);
    chk("R5 flag", irq_o, 0);
    count_to(1'b1, n);
    chk("R5 restart period", n, 10);

    // leaving inhibit: next wrap loads reload 1, divide 0
    wr(A_CTRL, 1);
    count_to(1'b0, n);
    count_to(1'b0, n);
    chk("R4 resumed period", n, 2);

    // R6: quiet forced update
    wr(A_CTRL, 4);
    wr(A_CMD, 0);
    wr(A_CMD, 3);
    chk("R6 update", update_o, 1);
    chk("R6 no flag", irq_o, 0);
    wr(A_CTRL, 5);
    count_to(1'b0, n);
    chk("R6 wrap flag", irq_o, 1);

    // R7: sticky flag and clearing
    wr(A_CTRL, 0);
    idle(20);
    chk("R7 sticky", irq_o, 1);
    wr(A_CMD, 2);
    chk("R7 keep", irq_o, 1);
    wr(A_CMD, 0);
    chk("R7 clear", irq_o, 0);

    // R8: hold when disabled, forced update still reloads
    held = cnt_o;
    idle(20);
    chk("R8 hold", cnt_o, held);
    wr(A_RLD, 9);
    wr(A_CMD, 1);
    chk("R8 reload", cnt_o, 9);
    idle(10);
    chk("R8 hold after", cnt_o, 9);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(4 * 200000);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule